// File: doc/BRIEF.md
# GPIO Interrupt Line Conditioner

This block turns a group of general-purpose input pins into interrupt requests for a parent interrupt controller. Every line passes through a two-flop synchroniser. It then goes through an optional glitch filter and a final output register. The line's own enable, mode and filter settings decide what the parent sees. One interrupt output exists per line, and software configures the block through four registers on a simple write/read bus.

The filter waits for a new input level to hold steady for a programmable number of cycles before it accepts that level. One period register sets this count for every line. Each line chooses for itself whether its filter is used.

A line in both-edge mode sits high. It shows a single-cycle low pulse for every accepted change in either direction, so a parent that is set to detect falling edges sees every change. Both-edge mode only takes effect when that line's filter is enabled. Otherwise the line forwards its synchronised level.

Top module: `gpio_irq_filter`

## Requirements
- R1: After reset, all four registers read 0 and every interrupt output is 0.
- R2: The registers are at these byte addresses: line enable at 0x90, both-edge mode at 0x94, filter enable at 0x98, and filter period at 0x9C. The period register holds the low PERIOD_W data bits. Bit i of the three per-line registers belongs to line i. A write takes effect on the clock edge where `bus_we` is high, and reads are combinational on `bus_addr`. Any other address reads 0, and a write to it changes no register.
- R3: A line whose enable bit is 0 holds its interrupt output at 0, whatever its input does.
- R4: With the filter bit at 0, an enabled line outputs its input level. The level appears on the 4th rising edge after the input changes. The both-edge mode bit has no effect in this case.
- R5: With the filter bit at 1 and period P, an input change is accepted only once it has been present for P+1 consecutive cycles. A shorter pulse leaves the output unchanged.
- R6: With the filter bit at 1 and the mode bit at 0, an accepted level appears on the output at the (P+4)th rising edge after the input change.
- R7: With the enable, mode and filter bits all at 1, the output idles at 1. Each accepted rising or falling change drives it to 0 for exactly one cycle, starting at the (P+4)th rising edge after the change.
- R8: One period value governs every line. Each line's filter bit is independent, and a new period applies to the next change that is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for `bus_addr` |
| gpio_in | input | NUM_LINES | Asynchronous input pins |
| irq_out | output | NUM_LINES | Interrupt request per line |

## Verification
Each line is driven with steps, short glitches and held levels under different settings. A step with the filter bypassed measures the base latency and shows that the mode bit is ignored there. A glitch one cycle shorter than the filter window separates a correct window from one that is off by one. A long hold then confirms the exact acceptance edge. In both-edge mode, rising and falling steps show a one-cycle low pulse in each direction. Two lines that receive the same pulse under one shared period, one filtered and one not, show that the period is shared while each filter enable stays separate.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
  localparam int unsigned OFS_ENABLE = 32'h90;
  localparam int unsigned OFS_MODE   = 32'h94;
  localparam int unsigned OFS_FILTER = 32'h98;
  localparam int unsigned OFS_PERIOD = 32'h9C;
endpackage

// File: rtl/gpirq_regs.sv
module gpirq_regs
  import gpirq_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int PERIOD_W  = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] en_o,
  output logic [NUM_LINES-1:0] mode_o,
  output logic [NUM_LINES-1:0] filt_o,
  output logic [PERIOD_W-1:0]  period_o
);
  logic [NUM_LINES-1:0] en_q, en_n, mode_q, mode_n, filt_q, filt_n;
  logic [PERIOD_W-1:0]  per_q, per_n;
  logic sel_en, sel_mode, sel_filt, sel_per;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign sel_en   = (bus_addr == ADDR_W'(OFS_ENABLE));
  assign sel_mode = (bus_addr == ADDR_W'(OFS_MODE));
  assign sel_filt = (bus_addr == ADDR_W'(OFS_FILTER));
  assign sel_per  = (bus_addr == ADDR_W'(OFS_PERIOD));

  always_comb begin
    en_n   = en_q;
    mode_n = mode_q;
    filt_n = filt_q;
    per_n  = per_q;
    if (bus_we) begin
      if (sel_en)   en_n   = bus_wdata[NUM_LINES-1:0];
      if (sel_mode) mode_n = bus_wdata[NUM_LINES-1:0];
      if (sel_filt) filt_n = bus_wdata[NUM_LINES-1:0];
      if (sel_per)  per_n  = bus_wdata[PERIOD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      filt_q <= '0;
      per_q  <= '0;
    end else begin
      en_q   <= en_n;
      mode_q <= mode_n;
      filt_q <= filt_n;
      per_q  <= per_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_en)   bus_rdata = DATA_W'(en_q);
    if (sel_mode) bus_rdata = DATA_W'(mode_q);
    if (sel_filt) bus_rdata = DATA_W'(filt_q);
    if (sel_per)  bus_rdata = DATA_W'(per_q);
  end

  assign en_o     = en_q;
  assign mode_o   = mode_q;
  assign filt_o   = filt_q;
  assign period_o = per_q;

  // R2: a write to the enable address lands in the register on the next cycle
  p_wr_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel_en) |=> (en_o == $past(bus_wdata[NUM_LINES-1:0])));
endmodule

// File: rtl/gpirq_line.sv
module gpirq_line #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin_i,
  input  logic                en_i,
  input  logic                both_i,
  input  logic                filt_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                irq_o
);
  logic s1_q, s2_q;
  logic lvl_q, lvl_n, lvl_d1_q;
  logic [PERIOD_W-1:0] cnt_q, cnt_n;
  logic irq_q, irq_n;
  logic both_act, changed;

  always_comb begin
    lvl_n = lvl_q;
    cnt_n = '0;
    if (!filt_i) begin
      lvl_n = s2_q;
    end else if (s2_q != lvl_q) begin
      if (cnt_q >= period_i) lvl_n = s2_q;
      else                   cnt_n = cnt_q + 1'b1;
    end
  end

  assign both_act = en_i & both_i & filt_i;
  assign changed  = lvl_q ^ lvl_d1_q;

  always_comb begin
    if (!en_i)         irq_n = 1'b0;
    else if (both_act) irq_n = ~changed;
    else               irq_n = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= 1'b0;
      s2_q     <= 1'b0;
      lvl_q    <= 1'b0;
      lvl_d1_q <= 1'b0;
      cnt_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      s1_q     <= pin_i;
      s2_q     <= s1_q;
      lvl_q    <= lvl_n;
      lvl_d1_q <= lvl_q;
      cnt_q    <= cnt_n;
      irq_q    <= irq_n;
    end
  end

  assign irq_o = irq_q;

  // R3: a masked line drives 0 on the next cycle
  p_mask_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !irq_o);

  // R5: with the filter on, a settled level never moves while the input agrees with it
  p_filter_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_i && (s2_q == lvl_q)) |=> (lvl_q == $past(lvl_q)));

  // R4: bypassed filter forwards the synchronised level two cycles later
  p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i && !filt_i) && $past(!filt_i, 2)) |-> (irq_o == $past(s2_q, 2)));

  // R7: a low output in both-edge mode always stems from an accepted change
  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(both_act) && !irq_o) |-> ($past(lvl_q) != $past(lvl_d1_q)));
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int NUM_LINES = 24,
  parameter int PERIOD_W  = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] gpio_in,
  output logic [NUM_LINES-1:0] irq_out
);
  logic rst_meta_q, rst_sync_q;
  logic [NUM_LINES-1:0] en, mode, filt;
  logic [PERIOD_W-1:0]  period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  gpirq_regs #(
    .NUM_LINES(NUM_LINES), .PERIOD_W(PERIOD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_o(en), .mode_o(mode),
    .filt_o(filt), .period_o(period)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    gpirq_line #(.PERIOD_W(PERIOD_W)) u_line (
      .clk(clk), .rst_n(rst_sync_q), .pin_i(gpio_in[i]), .en_i(en[i]),
      .both_i(mode[i]), .filt_i(filt[i]), .period_i(period), .irq_o(irq_out[i])
    );
  end
endmodule

// File: tb/gpio_irq_filter_tb.sv
module gpio_irq_filter_tb;
  localparam int N = 24;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] gpio_in = '0;
  logic [N-1:0] irq_out;
  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] en_v = '0, fen_v = '0;

  always #2 clk = ~clk;

  gpio_irq_filter u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk);
    gpio_in[i] = v;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h90, d); chk("R1 enable", d, 0);
    rd(8'h94, d); chk("R1 mode", d, 0);
    rd(8'h98, d); chk("R1 filter", d, 0);
    rd(8'h9C, d); chk("R1 period", d, 0);
    chk("R1 irq", 32'(irq_out), 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h94, 32'hFFA5_5A3C); rd(8'h94, d); chk("R2 mode readback", d, 32'h00A5_5A3C);
    wr(8'h9C, 32'h0000_01C7); rd(8'h9C, d); chk("R2 period width", d, 32'hC7);
    wr(8'h80, 32'hFFFF_FFFF); rd(8'h80, d); chk("R2 unmapped read", d, 0);
    rd(8'h94, d); chk("R2 unmapped write no effect", d, 32'h00A5_5A3C);
    rd(8'h90, d); chk("R2 enable untouched", d, 0);
    wr(8'h94, 0); wr(8'h9C, 0);
  endtask

  task automatic t_mask_and_level;
    logic seen;
    set_pin(0, 1'b1);
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin edges(1); seen |= irq_out[0]; end
    chk("R3 masked line stays low", 32'(seen), 0);
    en_v = 32'h1; wr(8'h90, en_v);
    edges(2); chk("R3 unmasked follows high input", 32'(irq_out[0]), 1);
    set_pin(0, 1'b0);
    edges(3); chk("R4 no change before 4th edge", 32'(irq_out[0]), 1);
    edges(1); chk("R4 level at 4th edge", 32'(irq_out[0]), 0);
    wr(8'h94, 32'h1);
    set_pin(0, 1'b1);
    edges(4); chk("R4 mode ignored rise", 32'(irq_out[0]), 1);
    edges(1); chk("R4 mode ignored hold", 32'(irq_out[0]), 1);
    set_pin(0, 1'b0);
    edges(4); chk("R4 mode ignored fall", 32'(irq_out[0]), 0);
    wr(8'h94, 0);
  endtask

  task automatic t_filter;
    logic seen;
    wr(8'h9C, 3);
    fen_v = 32'h2; wr(8'h98, fen_v);
    en_v = en_v | 32'h2; wr(8'h90, en_v);
    set_pin(1, 1'b1);
    repeat (3) @(negedge clk);
    gpio_in[1] = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 12; k++) begin edges(1); seen |= irq_out[1]; end
    chk("R5 glitch of P cycles rejected", 32'(seen), 0);
    set_pin(1, 1'b1);
    edges(6); chk("R6 not yet at edge P+3", 32'(irq_out[1]), 0);
    edges(1); chk("R6 accepted at edge P+4", 32'(irq_out[1]), 1);
    set_pin(1, 1'b0);
    edges(7); chk("R6 falling accepted at edge P+4", 32'(irq_out[1]), 0);
  endtask

  task automatic t_both;
    wr(8'h9C, 2);
    fen_v = fen_v | 32'h4; wr(8'h98, fen_v);
    wr(8'h94, 32'h4);
    en_v = en_v | 32'h4; wr(8'h90, en_v);
    edges(3); chk("R7 idle high", 32'(irq_out[2]), 1);
    set_pin(2, 1'b1);
    edges(5); chk("R7 rise still high at P+3", 32'(irq_out[2]), 1);
    edges(1); chk("R7 rise low at P+4", 32'(irq_out[2]), 0);
    edges(1); chk("R7 rise pulse one cycle", 32'(irq_out[2]), 1);
    set_pin(2, 1'b0);
    edges(6); chk("R7 fall low at P+4", 32'(irq_out[2]), 0);
    edges(1); chk("R7 fall pulse one cycle", 32'(irq_out[2]), 1);
    wr(8'h94, 0);
  endtask

  task automatic t_shared;
    logic seen;
    wr(8'h9C, 5);
    fen_v = fen_v | 32'h8; wr(8'h98, fen_v);
    en_v = en_v | 32'h18; wr(8'h90, en_v);
    edges(4);
    @(negedge clk); gpio_in[4:3] = 2'b11;
    repeat (3) @(negedge clk);
    gpio_in[4:3] = 2'b00;
    edges(1); chk("R8 unfiltered line passes pulse", 32'(irq_out[4]), 1);
    seen = 1'b0;
    for (int k = 0; k < 12; k++) begin edges(1); seen |= irq_out[3]; end
    chk("R8 filtered line rejects pulse under period 5", 32'(seen), 0);
    wr(8'h9C, 1);
    @(negedge clk); gpio_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    gpio_in[3] = 1'b0;
    edges(1); chk("R8 new period not yet accepted", 32'(irq_out[3]), 0);
    edges(1); chk("R8 new period accepts pulse", 32'(irq_out[3]), 1);
    edges(8);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_mask_and_level();
    t_filter();
    t_both();
    t_shared();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule